// File: doc/BRIEF.md
# Prefetch Line Address Sequencer

This block drives the address side of a read-prefetch engine that runs ahead of a bus master. A burst begins with a start pulse. The pulse carries a byte address and the number of cache lines the master asked for. The sequencer then presents one line-aligned address at a time. A consumer takes each address with a valid/ready handshake. The sequencer steps by one line per accepted address.

A burst ends for one of four reasons:

- the requested line count has been issued;
- the master terminates the burst;
- the next line would leave the region in which the bridge is a legal target;
- optionally, the next line would start a new 4 KB page.

Before it issues each line after the first, the sequencer checks that line against the address-window boundaries. Software-owned window bases and enable bits arrive as plain inputs. The first line of a burst is always issued, even when it sits on a boundary. A registered reason code and a one-cycle done pulse report how the burst ended.

Top module: `pf_line_seq`

## Requirements
- R1: After reset, `busy_o`, `line_valid_o` and `done_o` are 0 and `stop_code_o` is 0.
- R2: A `start_i` pulse while idle sets `busy_o` and `line_valid_o` on the next cycle. The first address is `start_addr_i` with its low log2(LINE_BYTES) bits cleared. This first line is issued even if it sits at a boundary.
- R3: Each accepted address (valid and ready both high) is followed by one that is exactly LINE_BYTES larger. While ready is low, the address holds.
- R4: When the handshake count reaches `burst_lines_i` (a value of 0 counts as 1), the burst ends. On the next cycle `busy_o` falls, `done_o` pulses for one cycle, and `stop_code_o` = 0 (done).
- R5: `stop_i` while busy ends the burst. On the next cycle `line_valid_o` is 0 and `stop_code_o` = 1 (master stop).
- R6: If the next line would wrap past the top of the 64-bit space, the burst ends after the current line with code 2 (range).
- R7: If the current line is below 0xFD_0000_0000 and the next line is at or above it, the burst ends with code 2. This check is always active.
- R8: The same crossing rule applies at `np_base_i` (code 2), but only while `np_en_i` = 1. When `np_en_i` = 0, that base has no effect.
- R9: The same crossing rule applies at `pf_base_i` (code 2), but only while `pf_en_i` = 1.
- R10: The same crossing rule applies at 0xA_0000 (code 2), but only while `vga_en_i` = 1.
- R11: With `page_stop_i` = 1, a next line whose address bits [11:0] are zero ends the burst with code 3 (page). When a range boundary and a page boundary fall on the same line, code 2 wins.
- R12: `start_i` while busy is ignored: the address sequence and line count continue unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a burst (ignored while busy) |
| start_addr_i | input | ADDR_W | Byte address of the first line |
| burst_lines_i | input | LEN_W | Lines requested by the master |
| stop_i | input | 1 | Master terminates the burst |
| line_valid_o | output | 1 | A line address is presented |
| line_addr_o | output | ADDR_W | Line-aligned address |
| line_ready_i | input | 1 | Consumer accepts the address |
| np_en_i | input | 1 | Non-prefetchable window boundary enable |
| np_base_i | input | ADDR_W | Non-prefetchable window base |
| pf_en_i | input | 1 | Prefetchable window boundary enable |
| pf_base_i | input | ADDR_W | Prefetchable window base |
| vga_en_i | input | 1 | Legacy video memory boundary enable |
| page_stop_i | input | 1 | Stop at every 4 KB page |
| busy_o | output | 1 | Burst in progress |
| done_o | output | 1 | One-cycle pulse when a burst ends |
| stop_code_o | output | 2 | 0 done, 1 master, 2 range, 3 page |

## Verification
The sweep places start addresses a few lines below, on, and just past every boundary. It covers every combination of the four enables and several burst lengths. The consumer's ready signal is stalled with a repeating gap pattern throughout.

These runs target specific faults:

- An off-by-one crossing test would either issue the line at the boundary or stop one line early. Both show up as a wrong line count.
- A design that checks the first line would refuse bursts that start on a boundary.
- A disabled window that is still compared would end bursts early.
- A reversed priority between page and range would report code 3 where 2 is expected.

Directed cases cover the wrap at the top of the 64-bit space, a master stop during a stall, and a restart pulse during a busy burst. A design that reloads on that pulse would show a jump in the address sequence.

// File: rtl/pf_seq_pkg.sv
package pf_seq_pkg;
  typedef enum logic [1:0] {
    STOP_DONE   = 2'd0,
    STOP_MASTER = 2'd1,
    STOP_RANGE  = 2'd2,
    STOP_PAGE   = 2'd3
  } stop_code_e;

  localparam logic [63:0] TOP40_BOUND = 64'h0000_00FD_0000_0000;
  localparam logic [63:0] VGA_BOUND   = 64'h0000_0000_000A_0000;
endpackage

// File: rtl/pf_cross_det.sv
module pf_cross_det #(
  parameter int ADDR_W = 64
) (
  input  logic              en_i,
  input  logic [ADDR_W-1:0] bound_i,
  input  logic [ADDR_W-1:0] cur_i,
  input  logic [ADDR_W-1:0] nxt_i,
  output logic              hit_o
);
  // step from below the bound to at-or-above it
  assign hit_o = en_i && (cur_i < bound_i) && (nxt_i >= bound_i);
endmodule

// File: rtl/pf_bound_chk.sv
module pf_bound_chk
  import pf_seq_pkg::*;
#(
  parameter int ADDR_W     = 64,
  parameter int LINE_BYTES = 64,
  parameter int PAGE_BYTES = 4096
) (
  input  logic [ADDR_W-1:0] cur_i,
  input  logic              np_en_i,
  input  logic [ADDR_W-1:0] np_base_i,
  input  logic              pf_en_i,
  input  logic [ADDR_W-1:0] pf_base_i,
  input  logic              vga_en_i,
  input  logic              page_stop_i,
  output logic [ADDR_W-1:0] nxt_o,
  output logic              range_hit_o,
  output logic              page_hit_o
);
  localparam int PAGE_W  = $clog2(PAGE_BYTES);
  localparam int NUM_BND = 4;

  logic [ADDR_W:0]   sum;
  logic              wrap;
  logic [ADDR_W-1:0] bnd [NUM_BND];
  logic [NUM_BND-1:0] bnd_en;
  logic [NUM_BND-1:0] bnd_hit;

  assign sum   = {1'b0, cur_i} + (ADDR_W+1)'(LINE_BYTES);
  assign wrap  = sum[ADDR_W];
  assign nxt_o = sum[ADDR_W-1:0];

  assign bnd[0] = ADDR_W'(TOP40_BOUND);
  assign bnd[1] = np_base_i;
  assign bnd[2] = pf_base_i;
  assign bnd[3] = ADDR_W'(VGA_BOUND);
  assign bnd_en = {vga_en_i, pf_en_i, np_en_i, 1'b1};

  for (genvar g = 0; g < NUM_BND; g++) begin : g_bnd
    pf_cross_det #(.ADDR_W(ADDR_W)) u_det (
      .en_i   (bnd_en[g]),
      .bound_i(bnd[g]),
      .cur_i  (cur_i),
      .nxt_i  (nxt_o),
      .hit_o  (bnd_hit[g])
    );
  end

  assign range_hit_o = wrap || (|bnd_hit);
  assign page_hit_o  = page_stop_i && (nxt_o[PAGE_W-1:0] == '0);
endmodule

// File: rtl/pf_addr_ctr.sv
module pf_addr_ctr #(
  parameter int ADDR_W     = 64,
  parameter int LINE_BYTES = 64,
  parameter int LEN_W      = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] load_addr_i,
  input  logic [LEN_W-1:0]  load_len_i,
  input  logic              step_i,
  input  logic [ADDR_W-1:0] nxt_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              last_o
);
  localparam int OFF_W = $clog2(LINE_BYTES);

  logic [ADDR_W-1:0] addr_q;
  logic [LEN_W-1:0]  left_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      left_q <= '0;
    end else if (load_i) begin
      addr_q <= {load_addr_i[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
      left_q <= load_len_i;
    end else if (step_i) begin
      addr_q <= nxt_i;
      left_q <= left_q - LEN_W'(1);
    end
  end

  assign addr_o = addr_q;
  assign last_o = (left_q <= LEN_W'(1));
endmodule

// File: rtl/pf_seq_ctrl.sv
module pf_seq_ctrl
  import pf_seq_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       stop_i,
  input  logic       fire_i,
  input  logic       last_i,
  input  logic       range_hit_i,
  input  logic       page_hit_i,
  output logic       busy_o,
  output logic       load_o,
  output logic       step_o,
  output logic       done_o,
  output stop_code_e code_o
);
  logic       busy_q, done_q, finish;
  stop_code_e code_q, code_d;

  always_comb begin
    load_o = start_i && !busy_q;
    step_o = 1'b0;
    finish = 1'b0;
    code_d = code_q;
    if (load_o) begin
      code_d = STOP_DONE;
    end else if (busy_q) begin
      if (stop_i) begin
        finish = 1'b1;
        code_d = STOP_MASTER;
      end else if (fire_i) begin
        // priority: count done, then range, then page
        if (last_i) begin
          finish = 1'b1;
          code_d = STOP_DONE;
        end else if (range_hit_i) begin
          finish = 1'b1;
          code_d = STOP_RANGE;
        end else if (page_hit_i) begin
          finish = 1'b1;
          code_d = STOP_PAGE;
        end else begin
          step_o = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      code_q <= STOP_DONE;
    end else begin
      busy_q <= load_o || (busy_q && !finish);
      done_q <= finish;
      code_q <= code_d;
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;
  assign code_o = code_q;
endmodule

// File: rtl/pf_line_seq.sv
module pf_line_seq
  import pf_seq_pkg::*;
#(
  parameter int ADDR_W     = 64,
  parameter int LINE_BYTES = 64,
  parameter int LEN_W      = 8,
  parameter int PAGE_BYTES = 4096
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] start_addr_i,
  input  logic [LEN_W-1:0]  burst_lines_i,
  input  logic              stop_i,
  output logic              line_valid_o,
  output logic [ADDR_W-1:0] line_addr_o,
  input  logic              line_ready_i,
  input  logic              np_en_i,
  input  logic [ADDR_W-1:0] np_base_i,
  input  logic              pf_en_i,
  input  logic [ADDR_W-1:0] pf_base_i,
  input  logic              vga_en_i,
  input  logic              page_stop_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [1:0]        stop_code_o
);
  logic              busy, load, step, last, range_hit, page_hit, fire;
  logic [ADDR_W-1:0] cur_addr, nxt_addr;
  stop_code_e        code;

  assign fire = busy && line_ready_i;

  pf_addr_ctr #(.ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES), .LEN_W(LEN_W)) u_ctr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load),
    .load_addr_i(start_addr_i),
    .load_len_i (burst_lines_i),
    .step_i     (step),
    .nxt_i      (nxt_addr),
    .addr_o     (cur_addr),
    .last_o     (last)
  );

  pf_bound_chk #(.ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES), .PAGE_BYTES(PAGE_BYTES)) u_bnd (
    .cur_i      (cur_addr),
    .np_en_i    (np_en_i),
    .np_base_i  (np_base_i),
    .pf_en_i    (pf_en_i),
    .pf_base_i  (pf_base_i),
    .vga_en_i   (vga_en_i),
    .page_stop_i(page_stop_i),
    .nxt_o      (nxt_addr),
    .range_hit_o(range_hit),
    .page_hit_o (page_hit)
  );

  pf_seq_ctrl u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .stop_i     (stop_i),
    .fire_i     (fire),
    .last_i     (last),
    .range_hit_i(range_hit),
    .page_hit_i (page_hit),
    .busy_o     (busy),
    .load_o     (load),
    .step_o     (step),
    .done_o     (done_o),
    .code_o     (code)
  );

  assign busy_o       = busy;
  assign line_valid_o = busy;
  assign line_addr_o  = cur_addr;
  assign stop_code_o  = code;
endmodule

// File: rtl/pf_line_seq_chk.sv
module pf_line_seq_chk #(
  parameter int ADDR_W     = 64,
  parameter int LINE_BYTES = 64
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic              stop_i,
  input logic              line_ready_i,
  input logic              line_valid_o,
  input logic [ADDR_W-1:0] line_addr_o,
  input logic              busy_o,
  input logic              done_o,
  input logic [1:0]        stop_code_o
);
  localparam int OFF_W = $clog2(LINE_BYTES);

  p_aligned_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_valid_o |-> (line_addr_o[OFF_W-1:0] == '0));

  p_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (line_valid_o && !line_ready_i && !stop_i) |=> (line_valid_o && $stable(line_addr_o)));

  p_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (line_valid_o && line_ready_i && !stop_i) |=>
      (!line_valid_o || (line_addr_o == $past(line_addr_o) + ADDR_W'(LINE_BYTES))));

  p_done_pulse_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_end_idle_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o);

  p_master_stop_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && stop_i) |=> (!line_valid_o && stop_code_o == 2'd1));

  p_restart_ignored_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i && !line_ready_i && !stop_i) |=> $stable(line_addr_o));
endmodule

bind pf_line_seq pf_line_seq_chk #(.ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (start_i),
  .stop_i      (stop_i),
  .line_ready_i(line_ready_i),
  .line_valid_o(line_valid_o),
  .line_addr_o (line_addr_o),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .stop_code_o (stop_code_o)
);

// File: tb/pf_line_seq_bench.sv
module pf_line_seq_bench;
  localparam int AW = 64;
  localparam int LB = 64;
  localparam int LW = 8;
  localparam logic [63:0] T40  = 64'h0000_00FD_0000_0000;
  localparam logic [63:0] VGA  = 64'h0000_0000_000A_0000;
  localparam logic [63:0] NP_B = 64'h0000_0000_8000_0000;
  localparam logic [63:0] PF_B = 64'h0000_0004_0000_0000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, stop = 1'b0, ready = 1'b0;
  logic [AW-1:0] saddr = '0, np_b = NP_B, pf_b = PF_B;
  logic [LW-1:0] blen = '0;
  logic np_en = 1'b0, pf_en = 1'b0, vga_en = 1'b0, pg_en = 1'b0;
  logic valid, busy, done;
  logic [AW-1:0] laddr;
  logic [1:0] code;
  int total = 0, bad = 0, cyc = 0;

  always #2 clk = ~clk;

  pf_line_seq u_pf_line_seq (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .start_addr_i(saddr),
    .burst_lines_i(blen), .stop_i(stop), .line_valid_o(valid), .line_addr_o(laddr),
    .line_ready_i(ready), .np_en_i(np_en), .np_base_i(np_b), .pf_en_i(pf_en),
    .pf_base_i(pf_b), .vga_en_i(vga_en), .page_stop_i(pg_en), .busy_o(busy),
    .done_o(done), .stop_code_o(code)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic crosses(input logic [63:0] c, input logic [63:0] n, input logic [63:0] b);
    return (c < b) && (n >= b);
  endfunction

  // expected line count, end code and the requirement that decides it
  task automatic model(input logic [63:0] sa, input int len, output int n,
                       output logic [1:0] ec, output string tag);
    logic [63:0] a;
    logic [64:0] s;
    a = {sa[63:6], 6'd0};
    n = 1;
    forever begin
      if (n >= len) begin ec = 2'd0; tag = "R4"; return; end
      s = {1'b0, a} + 65'd64;
      if (s[64]) begin ec = 2'd2; tag = "R6"; return; end
      if (crosses(a, s[63:0], T40)) begin ec = 2'd2; tag = "R7"; return; end
      if (np_en && crosses(a, s[63:0], np_b)) begin ec = 2'd2; tag = "R8"; return; end
      if (pf_en && crosses(a, s[63:0], pf_b)) begin ec = 2'd2; tag = "R9"; return; end
      if (vga_en && crosses(a, s[63:0], VGA)) begin ec = 2'd2; tag = "R10"; return; end
      if (pg_en && s[11:0] == 12'd0) begin ec = 2'd3; tag = "R11"; return; end
      a = s[63:0];
      n++;
    end
  endtask

  task automatic run(input logic [63:0] sa, input int len);
    int n_exp, idx, k, guard;
    logic [1:0] ec;
    string tag;
    logic [63:0] ea;
    model(sa, len, n_exp, ec, tag);
    saddr = sa; blen = LW'(len); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R2 valid after start", {63'd0, valid}, 64'd1);
    idx = 0; k = 0; guard = 0;
    ea = {sa[63:6], 6'd0};
    while (busy && guard < 200) begin
      chk(idx == 0 ? "R2 first addr" : "R3 addr", laddr, ea);
      ready = (k % 3) != 2;
      k++; guard++;
      @(negedge clk);
      if (ready) begin idx++; ea = ea + 64'd64; end
    end
    ready = 1'b0;
    chk({tag, " count"}, 64'(idx), 64'(n_exp));
    chk({tag, " code"}, {62'd0, code}, {62'd0, ec});
    chk("R4 done pulse", {63'd0, done}, 64'd1);
    @(negedge clk);
  endtask

  initial begin
    while (cyc < 190000) begin @(posedge clk); cyc++; end
    bad++; total++;
    $display("FAIL watchdog act=%0d exp=<190000", cyc);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [63:0] anchors [8];
    int lens [3];
    int k, idx;
    anchors[0] = T40; anchors[1] = NP_B; anchors[2] = PF_B; anchors[3] = VGA;
    anchors[4] = 64'hFFFF_FFFF_FFFF_FFC0; anchors[5] = 64'h0000_0000_0000_3000;
    anchors[6] = 64'h0000_0012_3456_7000; anchors[7] = 64'h0000_0000_0001_0000;
    lens[0] = 1; lens[1] = 3; lens[2] = 8;
    @(negedge clk);
    // R1 reset state
    chk("R1 busy", {63'd0, busy}, 64'd0);
    chk("R1 valid", {63'd0, valid}, 64'd0);
    chk("R1 done", {63'd0, done}, 64'd0);
    chk("R1 code", {62'd0, code}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int e = 0; e < 16; e++) begin
      {pg_en, vga_en, pf_en, np_en} = 4'(e);
      for (int a = 0; a < 8; a++)
        for (int off = -5; off <= 1; off++)
          for (int l = 0; l < 3; l++)
            run(anchors[a] + 64'(off * 64) + ((off % 2 != 0) ? 64'h13 : 64'h0), lens[l]);
    end

    // R6 wrap at the top of the 64-bit space, length 0 counts as one line
    {pg_en, vga_en, pf_en, np_en} = 4'b0000;
    run(64'hFFFF_FFFF_FFFF_FF00, 10);
    run(64'h0000_0000_0000_0100, 0);

    // R11 range and page on the same line: range wins
    pg_en = 1'b1;
    run(T40 - 64'd128, 8);
    pg_en = 1'b0;

    // R5 master stop during a stall
    saddr = 64'h1000; blen = 8'd20; start = 1'b1;
    @(negedge clk);
    start = 1'b0; ready = 1'b1;
    @(negedge clk); @(negedge clk);
    ready = 1'b0; stop = 1'b1;
    @(negedge clk);
    stop = 1'b0;
    chk("R5 valid low", {63'd0, valid}, 64'd0);
    chk("R5 code", {62'd0, code}, 64'd1);
    chk("R5 done", {63'd0, done}, 64'd1);
    @(negedge clk);

    // R12 restart while busy is ignored
    saddr = 64'h2000; blen = 8'd4; start = 1'b1;
    @(negedge clk);
    saddr = 64'h9000; ready = 1'b1;
    idx = 0;
    for (k = 0; k < 8 && busy; k++) begin
      chk("R12 addr", laddr, 64'h2000 + 64'(idx * 64));
      @(negedge clk);
      idx++;
      start = 1'b0;
    end
    ready = 1'b0;
    chk("R12 count", 64'(idx), 64'd4);
    chk("R12 code", {62'd0, code}, 64'd0);
    @(negedge clk);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule